// File: doc/BRIEF.md
# Fault Injection Campaign Sequencer

This block runs a bit-flip campaign over a window of configuration memory. It picks each flip location inside a programmable location window. It hands the location to a reconfiguration engine through an inject request/acknowledge pair. It then starts a functional test through a second handshake and waits for a pass or fail verdict. After the verdict it decides, according to the campaign mode, whether the original frame contents must be written back through a third handshake. It also decides whether the campaign is over.

A location is a single index of `FRAME_W + BIT_W` bits. The upper `FRAME_W` bits are the frame address and the lower `BIT_W` bits are the bit offset inside that frame. Three modes are available:
- **Walk:** locations are visited in ascending order, and each flip is repaired right after its test.
- **Pile-up:** locations are pseudo-random, and flips are never repaired.
- **Pile-up with periodic scrub:** locations are pseudo-random, and all accumulated damage is repaired after every N tested flips.

Each injection may flip a small group of adjacent bits. A counter of accepted injections is exported so that test results can be tagged with it.

Top module: `fi_campaign_seq`

## Requirements
- R1: A start pulse is accepted only while the block is idle or done. Accepting it latches mode, stop selection, window, seed, group size, scrub period and flip limit, and clears the fault counter and error code. A start pulse during a campaign has no effect on the locations issued or on the counter.
- R2: Every issued location `{inj_frame_o, inj_bit_o}` lies inside `[lo_loc_i, hi_loc_i]` as latched at start. If the window is empty (`lo > hi`), the block goes to done with `err_code_o = 3` and issues no request.
- R3: In walk mode (`mode_i = 0`), locations are `lo, lo+1, ...`. Each tested flip is followed by one restore request with `rst_all_o = 0`. The campaign ends after the location equal to `hi` has been handled.
- R4: In the random modes (`mode_i = 1, 2, 3`), a 32-bit register is loaded with `seed_i`, or with 1 if the seed is 0. During location selection, one candidate per cycle is taken from the low `FRAME_W + BIT_W` bits of the register. After each candidate the register steps: shift right by one, and if the bit shifted out was 1, XOR with `32'h8020_0003`. Out-of-window candidates are discarded, never folded into the window.
- R5: In pile-up mode (`mode_i = 1`), no restore request is ever issued.
- R6: In scrub mode (`mode_i = 2` or `3`), after every `clean_n_i`-th tested flip one restore request with `rst_all_o = 1` is issued, and no restore is issued otherwise. A period of 0 acts as 1.
- R7: The stop selection is checked after the restore step of each flip. The encodings are: 0 = none; 1 = a failed test has been seen; 2 = fault counter has reached `flip_limit_i`; 3 = either of the two.
- R8: `fault_cnt_o` rises by exactly one for each inject acknowledge without error, one cycle after the acknowledge, and changes at no other time except the clear at start.
- R9: The inject request stays high with a stable location until acknowledged. The test request follows the acknowledge, and the restore request follows the test verdict. No two requests are ever high together.
- R10: An inject acknowledge with `inj_err_i` ends the campaign with `err_code_o = 1`. A restore acknowledge with `rst_err_i` ends it with `err_code_o = 2`. In both cases no further request is issued, and a failed inject is not counted.
- R11: `inj_nbits_o` carries the `nbits_i` value latched at start for every injection of the campaign.
- R12: After reset no request is high, `busy_o` and `done_o` are low, and the counter and error code are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a campaign (pulse) |
| mode_i | input | 2 | 0 walk, 1 pile-up, 2/3 pile-up with scrub |
| stop_sel_i | input | 2 | 0 none, 1 first fail, 2 flip limit, 3 either |
| lo_loc_i | input | FRAME_W+BIT_W | Lowest allowed location |
| hi_loc_i | input | FRAME_W+BIT_W | Highest allowed location |
| seed_i | input | 32 | Random generator seed |
| nbits_i | input | NB_W | Adjacent-bit group size code |
| clean_n_i | input | CNT_W | Tested flips between scrubs |
| flip_limit_i | input | CNT_W | Flip count that ends the campaign |
| inj_req_o | output | 1 | Inject command request |
| inj_frame_o | output | FRAME_W | Frame address of the flip |
| inj_bit_o | output | BIT_W | Bit offset in the frame |
| inj_nbits_o | output | NB_W | Group size code of the flip |
| inj_ack_i | input | 1 | Inject done |
| inj_err_i | input | 1 | Inject failed (with ack) |
| test_req_o | output | 1 | Functional test request |
| test_done_i | input | 1 | Test finished |
| test_fail_i | input | 1 | Test mismatch (with done) |
| rst_req_o | output | 1 | Restore request |
| rst_all_o | output | 1 | 1 restore all damaged frames, 0 last frame only |
| rst_ack_i | input | 1 | Restore done |
| rst_err_i | input | 1 | Restore failed (with ack) |
| fault_cnt_o | output | CNT_W | Accepted injections this campaign |
| busy_o | output | 1 | Campaign running |
| done_o | output | 1 | Campaign finished |
| err_code_o | output | 2 | 0 ok, 1 inject, 2 restore, 3 empty window |

## Verification
A corrupted random register or walk counter shows at the very next inject request as a location that differs from the reference model's. Since every request is compared, a single wrong step is caught within one flip. A wrong scrub count or a restore decision in the wrong mode appears as an unexpected or missing restore request before the next inject request. A drifted fault counter differs from the model's count on the first clock after the acknowledge. A stop decision that is wrong shows as `done_o` rising too early or too late against the model's flip and restore totals.

// File: rtl/fi_seq_pkg.sv
package fi_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_INJECT, S_WAIT_ACK, S_TEST, S_RESTORE, S_NEXT, S_DONE
  } state_e;

  localparam logic [1:0] MODE_SEQ   = 2'd0;
  localparam logic [1:0] MODE_ACC   = 2'd1;

  localparam logic [1:0] ERR_NONE  = 2'd0;
  localparam logic [1:0] ERR_INJ   = 2'd1;
  localparam logic [1:0] ERR_RST   = 2'd2;
  localparam logic [1:0] ERR_RANGE = 2'd3;

  localparam logic [31:0] LFSR_TAPS = 32'h8020_0003;

  function automatic logic [31:0] lfsr_step(input logic [31:0] v);
    return v[0] ? ({1'b0, v[31:1]} ^ LFSR_TAPS) : {1'b0, v[31:1]};
  endfunction
endpackage

// File: rtl/fi_loc_gen.sv
module fi_loc_gen
  import fi_seq_pkg::*;
#(
  parameter int LOC_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             rand_i,
  input  logic             draw_i,
  input  logic             adv_i,
  input  logic [LOC_W-1:0] start_loc_i,
  input  logic [LOC_W-1:0] lo_i,
  input  logic [LOC_W-1:0] hi_i,
  input  logic [31:0]      seed_i,
  output logic [LOC_W-1:0] cand_o,
  output logic             cand_ok_o
);
  logic [31:0]      lfsr_q;
  logic [LOC_W-1:0] seq_q;
  logic [LOC_W-1:0] rnd;

  if (LOC_W >= 32) begin : g_wide
    assign rnd = LOC_W'(lfsr_q);
  end else begin : g_narrow
    assign rnd = lfsr_q[LOC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lfsr_q <= 32'h1;
      seq_q  <= '0;
    end else if (load_i) begin
      lfsr_q <= (seed_i == 32'h0) ? 32'h1 : seed_i;
      seq_q  <= start_loc_i;
    end else begin
      if (draw_i && rand_i) lfsr_q <= lfsr_step(lfsr_q);
      if (adv_i) seq_q <= seq_q + 1'b1;
    end
  end

  assign cand_o    = rand_i ? rnd : seq_q;
  assign cand_ok_o = rand_i ? ((rnd >= lo_i) && (rnd <= hi_i)) : 1'b1;
endmodule

// File: rtl/fi_restore_sched.sv
module fi_restore_sched
  import fi_seq_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [1:0]       mode_i,
  input  logic             tested_i,
  input  logic             restored_i,
  input  logic [CNT_W-1:0] clean_n_i,
  output logic             need_o,
  output logic             all_o
);
  logic [CNT_W-1:0] since_q;
  logic [CNT_W-1:0] since_inc;
  logic             need_q, all_q;

  assign since_inc = since_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q <= '0;
      need_q  <= 1'b0;
      all_q   <= 1'b0;
    end else if (clear_i) begin
      since_q <= '0;
      need_q  <= 1'b0;
      all_q   <= 1'b0;
    end else if (tested_i) begin
      if (mode_i == MODE_SEQ) begin
        need_q <= 1'b1;
        all_q  <= 1'b0;
      end else if (mode_i[1]) begin
        // period 0 behaves as 1 because since_inc >= 0 always holds
        if (since_inc >= clean_n_i) begin
          need_q  <= 1'b1;
          all_q   <= 1'b1;
          since_q <= '0;
        end else begin
          since_q <= since_inc;
        end
      end
    end else if (restored_i) begin
      need_q <= 1'b0;
      all_q  <= 1'b0;
    end
  end

  assign need_o = need_q;
  assign all_o  = all_q;
endmodule

// File: rtl/fi_stop_eval.sv
module fi_stop_eval #(
  parameter int CNT_W = 32
) (
  input  logic [1:0]       stop_sel_i,
  input  logic             fail_seen_i,
  input  logic             seq_mode_i,
  input  logic             seq_last_i,
  input  logic [CNT_W-1:0] fault_cnt_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             stop_o
);
  logic fault_hit, count_hit, walk_end;

  assign fault_hit = stop_sel_i[0] && fail_seen_i;
  assign count_hit = stop_sel_i[1] && (fault_cnt_i >= limit_i);
  assign walk_end  = seq_mode_i && seq_last_i;
  assign stop_o    = fault_hit || count_hit || walk_end;
endmodule

// File: rtl/fi_campaign_seq.sv
module fi_campaign_seq
  import fi_seq_pkg::*;
#(
  parameter int FRAME_W = 10,
  parameter int BIT_W   = 5,
  parameter int NB_W    = 3,
  parameter int CNT_W   = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [1:0]               mode_i,
  input  logic [1:0]               stop_sel_i,
  input  logic [FRAME_W+BIT_W-1:0] lo_loc_i,
  input  logic [FRAME_W+BIT_W-1:0] hi_loc_i,
  input  logic [31:0]              seed_i,
  input  logic [NB_W-1:0]          nbits_i,
  input  logic [CNT_W-1:0]         clean_n_i,
  input  logic [CNT_W-1:0]         flip_limit_i,
  output logic                     inj_req_o,
  output logic [FRAME_W-1:0]       inj_frame_o,
  output logic [BIT_W-1:0]         inj_bit_o,
  output logic [NB_W-1:0]          inj_nbits_o,
  input  logic                     inj_ack_i,
  input  logic                     inj_err_i,
  output logic                     test_req_o,
  input  logic                     test_done_i,
  input  logic                     test_fail_i,
  output logic                     rst_req_o,
  output logic                     rst_all_o,
  input  logic                     rst_ack_i,
  input  logic                     rst_err_i,
  output logic [CNT_W-1:0]         fault_cnt_o,
  output logic                     busy_o,
  output logic                     done_o,
  output logic [1:0]               err_code_o
);
  localparam int LOC_W = FRAME_W + BIT_W;

  state_e           state_q;
  logic [1:0]       cfg_mode_q, cfg_stop_q;
  logic [LOC_W-1:0] cfg_lo_q, cfg_hi_q, loc_q;
  logic [NB_W-1:0]  cfg_nb_q;
  logic [CNT_W-1:0] cfg_clean_q, cfg_limit_q, fault_cnt_q;
  logic             fail_seen_q;
  logic [1:0]       err_q;

  logic             accept, range_bad, rand_mode;
  logic [LOC_W-1:0] cand;
  logic             cand_ok, need, need_all, stop;
  logic             tested, restored, advance;

  assign accept    = ((state_q == S_IDLE) || (state_q == S_DONE)) && start_i;
  assign range_bad = lo_loc_i > hi_loc_i;
  assign rand_mode = cfg_mode_q != MODE_SEQ;
  assign tested    = (state_q == S_TEST) && test_done_i;
  assign restored  = (state_q == S_RESTORE) && need && rst_ack_i && !rst_err_i;
  assign advance   = (state_q == S_NEXT) && !stop;

  fi_loc_gen #(.LOC_W(LOC_W)) u_gen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (accept),
    .rand_i      (rand_mode),
    .draw_i      (state_q == S_INJECT),
    .adv_i       (advance),
    .start_loc_i (lo_loc_i),
    .lo_i        (cfg_lo_q),
    .hi_i        (cfg_hi_q),
    .seed_i      (seed_i),
    .cand_o      (cand),
    .cand_ok_o   (cand_ok)
  );

  fi_restore_sched #(.CNT_W(CNT_W)) u_sched (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (accept),
    .mode_i     (cfg_mode_q),
    .tested_i   (tested),
    .restored_i (restored),
    .clean_n_i  (cfg_clean_q),
    .need_o     (need),
    .all_o      (need_all)
  );

  fi_stop_eval #(.CNT_W(CNT_W)) u_stop (
    .stop_sel_i  (cfg_stop_q),
    .fail_seen_i (fail_seen_q),
    .seq_mode_i  (!rand_mode),
    .seq_last_i  (loc_q == cfg_hi_q),
    .fault_cnt_i (fault_cnt_q),
    .limit_i     (cfg_limit_q),
    .stop_o      (stop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      cfg_mode_q  <= MODE_SEQ;
      cfg_stop_q  <= '0;
      cfg_lo_q    <= '0;
      cfg_hi_q    <= '0;
      cfg_nb_q    <= '0;
      cfg_clean_q <= '0;
      cfg_limit_q <= '0;
      loc_q       <= '0;
      fault_cnt_q <= '0;
      fail_seen_q <= 1'b0;
      err_q       <= ERR_NONE;
    end else begin
      unique case (state_q)
        S_IDLE, S_DONE: begin
          if (start_i) begin
            cfg_mode_q  <= mode_i;
            cfg_stop_q  <= stop_sel_i;
            cfg_lo_q    <= lo_loc_i;
            cfg_hi_q    <= hi_loc_i;
            cfg_nb_q    <= nbits_i;
            cfg_clean_q <= clean_n_i;
            cfg_limit_q <= flip_limit_i;
            fault_cnt_q <= '0;
            fail_seen_q <= 1'b0;
            err_q       <= range_bad ? ERR_RANGE : ERR_NONE;
            state_q     <= range_bad ? S_DONE : S_INJECT;
          end
        end
        S_INJECT: begin
          if (cand_ok) begin
            loc_q   <= cand;
            state_q <= S_WAIT_ACK;
          end
        end
        S_WAIT_ACK: begin
          if (inj_ack_i) begin
            if (inj_err_i) begin
              err_q   <= ERR_INJ;
              state_q <= S_DONE;
            end else begin
              fault_cnt_q <= fault_cnt_q + 1'b1;
              state_q     <= S_TEST;
            end
          end
        end
        S_TEST: begin
          if (test_done_i) begin
            fail_seen_q <= fail_seen_q | test_fail_i;
            state_q     <= S_RESTORE;
          end
        end
        S_RESTORE: begin
          if (!need) begin
            state_q <= S_NEXT;
          end else if (rst_ack_i) begin
            if (rst_err_i) begin
              err_q   <= ERR_RST;
              state_q <= S_DONE;
            end else begin
              state_q <= S_NEXT;
            end
          end
        end
        S_NEXT:  state_q <= stop ? S_DONE : S_INJECT;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign inj_req_o   = state_q == S_WAIT_ACK;
  assign inj_frame_o = loc_q[LOC_W-1:BIT_W];
  assign inj_bit_o   = loc_q[BIT_W-1:0];
  assign inj_nbits_o = cfg_nb_q;
  assign test_req_o  = state_q == S_TEST;
  assign rst_req_o   = (state_q == S_RESTORE) && need;
  assign rst_all_o   = rst_req_o && need_all;
  assign fault_cnt_o = fault_cnt_q;
  assign busy_o      = (state_q != S_IDLE) && (state_q != S_DONE);
  assign done_o      = state_q == S_DONE;
  assign err_code_o  = err_q;
endmodule

// File: rtl/fi_campaign_seq_chk.sv
module fi_campaign_seq_chk
  import fi_seq_pkg::*;
#(
  parameter int FRAME_W = 10,
  parameter int BIT_W   = 5,
  parameter int CNT_W   = 32
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     inj_req_o,
  input logic                     inj_ack_i,
  input logic                     inj_err_i,
  input logic [FRAME_W-1:0]       inj_frame_o,
  input logic [BIT_W-1:0]         inj_bit_o,
  input logic                     test_req_o,
  input logic                     rst_req_o,
  input logic                     rst_all_o,
  input logic [CNT_W-1:0]         fault_cnt_o,
  input logic                     busy_o,
  input logic                     done_o,
  input logic [FRAME_W+BIT_W-1:0] cfg_lo_q,
  input logic [FRAME_W+BIT_W-1:0] cfg_hi_q,
  input logic [1:0]               cfg_mode_q
);
  logic [FRAME_W+BIT_W-1:0] loc;
  assign loc = {inj_frame_o, inj_bit_o};

  a_r9_one_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({inj_req_o, test_req_o, rst_req_o}));

  a_r9_inject_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_req_o && !inj_ack_i |=> inj_req_o && $stable(inj_frame_o) && $stable(inj_bit_o));

  a_r8_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_req_o && inj_ack_i && !inj_err_i |=> fault_cnt_o == $past(fault_cnt_o) + 1'b1);

  a_r2_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_req_o |-> (loc >= cfg_lo_q) && (loc <= cfg_hi_q));

  a_r5_no_restore_pileup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> cfg_mode_q != MODE_ACC);

  a_r6_scrub_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o && cfg_mode_q[1] |-> rst_all_o);

  a_r3_walk_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o && (cfg_mode_q == MODE_SEQ) |-> !rst_all_o);

  a_r10_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !inj_req_o && !test_req_o && !rst_req_o);

  a_r12_busy_done_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
endmodule

bind fi_campaign_seq fi_campaign_seq_chk #(
  .FRAME_W (FRAME_W),
  .BIT_W   (BIT_W),
  .CNT_W   (CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .inj_req_o   (inj_req_o),
  .inj_ack_i   (inj_ack_i),
  .inj_err_i   (inj_err_i),
  .inj_frame_o (inj_frame_o),
  .inj_bit_o   (inj_bit_o),
  .test_req_o  (test_req_o),
  .rst_req_o   (rst_req_o),
  .rst_all_o   (rst_all_o),
  .fault_cnt_o (fault_cnt_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .cfg_lo_q    (cfg_lo_q),
  .cfg_hi_q    (cfg_hi_q),
  .cfg_mode_q  (cfg_mode_q)
);

// File: tb/sim_fi_campaign_seq.sv
`timescale 1ns/1ps
module sim_fi_campaign_seq;
  localparam int FRAME_W = 10;
  localparam int BIT_W   = 5;
  localparam int NB_W    = 3;
  localparam int CNT_W   = 32;
  localparam int LOC_W   = FRAME_W + BIT_W;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode = '0, stop_sel = '0;
  logic [LOC_W-1:0] lo = '0, hi = '0;
  logic [31:0] seed = '0;
  logic [NB_W-1:0] nbits = '0;
  logic [CNT_W-1:0] clean_n = '0, limit = '0;
  logic inj_ack = 1'b0, inj_err = 1'b0, test_done = 1'b0, test_fail = 1'b0;
  logic rst_ack = 1'b0, rst_err = 1'b0;
  logic inj_req, test_req, rst_req, rst_all, busy, done;
  logic [FRAME_W-1:0] inj_frame;
  logic [BIT_W-1:0] inj_bit;
  logic [NB_W-1:0] inj_nbits;
  logic [CNT_W-1:0] fault_cnt;
  logic [1:0] err_code;

  fi_campaign_seq #(.FRAME_W(FRAME_W), .BIT_W(BIT_W), .NB_W(NB_W), .CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .stop_sel_i(stop_sel),
    .lo_loc_i(lo), .hi_loc_i(hi), .seed_i(seed), .nbits_i(nbits), .clean_n_i(clean_n),
    .flip_limit_i(limit), .inj_req_o(inj_req), .inj_frame_o(inj_frame), .inj_bit_o(inj_bit),
    .inj_nbits_o(inj_nbits), .inj_ack_i(inj_ack), .inj_err_i(inj_err), .test_req_o(test_req),
    .test_done_i(test_done), .test_fail_i(test_fail), .rst_req_o(rst_req), .rst_all_o(rst_all),
    .rst_ack_i(rst_ack), .rst_err_i(rst_err), .fault_cnt_o(fault_cnt), .busy_o(busy),
    .done_o(done), .err_code_o(err_code)
  );

  int n_chk = 0, n_fail = 0;
  bit active = 0;

  // reference model state
  logic [1:0] m_mode;
  logic [LOC_W-1:0] m_loc, m_lo, m_hi;
  logic [31:0] m_lfsr;
  logic [NB_W-1:0] m_nb;
  int m_cnt, m_since, m_period, m_inj, m_tst, m_rsti, m_rst;
  int fail_at, inj_err_at, rst_err_at;
  bit m_pend, m_all, p_inj, p_rst, p_done;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_next(output logic [LOC_W-1:0] l);
    logic [LOC_W-1:0] c;
    bit fb;
    if (m_mode == 2'd0) begin
      l = m_loc;
      m_loc = m_loc + 1'b1;
    end else begin
      do begin
        c = m_lfsr[LOC_W-1:0];
        fb = m_lfsr[0];
        m_lfsr = m_lfsr >> 1;
        if (fb) m_lfsr = m_lfsr ^ 32'h8020_0003;
      end while (c < m_lo || c > m_hi);
      l = c;
    end
  endtask

  always @(negedge clk) begin
    logic [LOC_W-1:0] e;
    if (active) begin
      // handshakes consumed at the edge just passed
      if (inj_ack && !inj_err) m_cnt++;
      if (test_done) begin
        if (m_mode == 2'd0) begin
          m_pend = 1; m_all = 0;
        end else if (m_mode[1]) begin
          m_since++;
          if (m_since >= m_period) begin m_pend = 1; m_all = 1; m_since = 0; end
        end
      end
      chk(fault_cnt == CNT_W'(m_cnt), "R8", fault_cnt, m_cnt);
      if (inj_req && !p_inj) begin
        chk(!m_pend, "R6 restore missing before next inject", 0, 1);
        model_next(e);
        chk({inj_frame, inj_bit} == e, (m_mode == 2'd0) ? "R3" : "R4", {inj_frame, inj_bit}, e);
        chk(inj_nbits == m_nb, "R11", inj_nbits, m_nb);
      end
      if (rst_req && !p_rst) begin
        chk(m_pend, "R5 unexpected restore", 1, 0);
        chk(rst_all == m_all, "R6 restore scope", rst_all, m_all);
        m_pend = 0;
        m_rst++;
      end
      if (done && !p_done) chk(!m_pend, "R7 done with restore owed", 1, 0);
      chk(!(inj_req && test_req) && !(inj_req && rst_req) && !(test_req && rst_req),
          "R9", {inj_req, test_req, rst_req}, 0);
      p_inj = inj_req; p_rst = rst_req; p_done = done;
      // responders
      if (inj_req && !inj_ack) begin
        m_inj++;
        inj_ack <= 1'b1;
        inj_err <= (m_inj == inj_err_at);
      end else begin
        inj_ack <= 1'b0; inj_err <= 1'b0;
      end
      if (test_req && !test_done) begin
        m_tst++;
        test_done <= 1'b1;
        test_fail <= (m_tst == fail_at);
      end else begin
        test_done <= 1'b0; test_fail <= 1'b0;
      end
      if (rst_req && !rst_ack) begin
        m_rsti++;
        rst_ack <= 1'b1;
        rst_err <= (m_rsti == rst_err_at);
      end else begin
        rst_ack <= 1'b0; rst_err <= 1'b0;
      end
    end
  end

  task automatic launch(input logic [1:0] md, input logic [1:0] st, input int l, input int h,
                        input int sd, input int cn, input int lim, input int nb,
                        input int f_at, input int ie_at, input int re_at);
    @(negedge clk); #1;
    mode = md; stop_sel = st; lo = LOC_W'(l); hi = LOC_W'(h); seed = sd;
    clean_n = cn; limit = lim; nbits = NB_W'(nb);
    m_mode = md; m_lo = LOC_W'(l); m_hi = LOC_W'(h); m_loc = LOC_W'(l);
    m_lfsr = (sd == 0) ? 32'h1 : sd; m_nb = NB_W'(nb);
    m_period = (cn == 0) ? 1 : cn;
    m_cnt = 0; m_since = 0; m_inj = 0; m_tst = 0; m_rsti = 0; m_rst = 0;
    m_pend = 0; m_all = 0;
    fail_at = f_at; inj_err_at = ie_at; rst_err_at = re_at;
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
  endtask

  task automatic finish_check(input string tag, input int e_err, input int e_cnt,
                              input int e_inj, input int e_rst);
    while (!done) @(negedge clk);
    @(negedge clk); #1;
    chk(err_code == 2'(e_err), tag, err_code, e_err);
    chk(fault_cnt == CNT_W'(e_cnt), tag, fault_cnt, e_cnt);
    chk(m_inj == e_inj, tag, m_inj, e_inj);
    chk(m_rst == e_rst, tag, m_rst, e_rst);
    chk(!busy, tag, busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R7 watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R12 reset state
    chk(!inj_req && !test_req && !rst_req, "R12 requests", {inj_req, test_req, rst_req}, 0);
    chk(!busy && !done, "R12 status", {busy, done}, 0);
    chk(fault_cnt == '0 && err_code == 2'd0, "R12 counter", fault_cnt, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    active = 1;

    // R3 walk over five locations, no stop selection
    launch(2'd0, 2'd0, 16, 20, 0, 0, 0, 0, 0, 0, 0);
    finish_check("R3 walk", 0, 5, 5, 5);

    // R4 R7 pile-up, random, stop at 6 flips, group code 3; mid-run start ignored (R1)
    launch(2'd1, 2'd2, 100, 160, 32'h1234_5678, 0, 6, 3, 0, 0, 0);
    while (m_inj < 2) @(negedge clk);
    #1;
    lo = '0; hi = 15'd5; mode = 2'd0; start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0; lo = 15'd100; hi = 15'd160; mode = 2'd1;
    finish_check("R1 R5 pile-up", 0, 6, 6, 0);

    // R6 scrub every 3 flips, zero seed, stop at 7
    launch(2'd2, 2'd2, 0, 4095, 0, 3, 7, 1, 0, 0, 0);
    finish_check("R6 scrub", 0, 7, 7, 2);

    // R6 scrub period 0 acts as 1, mode code 3
    launch(2'd3, 2'd2, 300, 2000, 32'hCAFE_F00D, 0, 3, 2, 0, 0, 0);
    finish_check("R6 period zero", 0, 3, 3, 3);

    // R7 stop on first failing test (fourth)
    launch(2'd0, 2'd1, 0, 20, 0, 0, 0, 0, 4, 0, 0);
    finish_check("R7 first fail", 0, 4, 4, 4);

    // R7 either condition, limit reached before any fail
    launch(2'd1, 2'd3, 500, 3000, 32'h0BAD_BEEF, 0, 2, 0, 9, 0, 0);
    finish_check("R7 either", 0, 2, 2, 0);

    // R10 inject error on second attempt
    launch(2'd1, 2'd0, 200, 999, 32'h5555_AAAA, 0, 0, 0, 0, 2, 0);
    finish_check("R10 inject error", 1, 1, 2, 0);

    // R10 restore error on first restore
    launch(2'd0, 2'd0, 40, 60, 0, 0, 0, 0, 0, 0, 1);
    finish_check("R10 restore error", 2, 1, 1, 1);

    // R2 empty window
    launch(2'd1, 2'd0, 50, 10, 7, 0, 0, 0, 0, 0, 0);
    finish_check("R2 empty window", 3, 0, 0, 0);

    // R2 single-location window, walk
    launch(2'd0, 2'd0, 7, 7, 0, 0, 0, 0, 0, 0, 0);
    finish_check("R2 single location", 0, 1, 1, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule